// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block stands in for the control registers of an audio codec's mixer. A host reaches it through a simple single-cycle access port. Each access carries a byte address, a size code and, for writes, 16 bits of data. Only 16-bit accesses to even offsets inside a 256-byte window reach the 128 stored words. Every other access reads as all ones and changes nothing.

Most offsets store whatever is written. A few get special treatment:

- The power-state register keeps its low status nibble.
- The identification words cannot be changed.
- The record-source register drops unused source bits.
- Many feature registers are fixed at zero.
- The sample-rate words follow the variable-rate enables held in the extended-control register.

Downstream logic reads the decoded results directly from output pins: mute flags, left and right volume scaled to 0..255, record sources, and the five sample rates.

Top module: `mixer_regfile`

## Requirements
- R1: After reset every word reads 0x0000, except these: power state (0x26) = 0x000F, identification words 0x7C = 0x8384 and 0x7E = 0x7600, extended ID (0x28) = 0x0809, extended control (0x2A) = 0x0009.
- R2: After reset the five rate words (0x2C, 0x2E, 0x30, 0x32, 0x34) read 0xBB80. Master volume (0x02) reads 0x8000. PCM-out volume (0x18) and record gain (0x1C) read 0x8808.
- R3: A write to 0x26 stores the written bits [15:4] with the previously stored bits [3:0].
- R4: Writes to 0x7C, 0x7E and 0x28 leave those words unchanged.
- R5: Writes to 0x2C and 0x32 are stored only while bit 0 (variable-rate audio) of 0x2A is 1. Writes to 0x34 are stored only while bit 3 (variable-rate mic) of 0x2A is 1. Writes to 0x2E and 0x30 are always stored.
- R6: A write to 0x2A always stores the written value. If that value has bit 0 clear, 0x2C and 0x32 become 0xBB80 in the same cycle. If it has bit 3 clear, 0x34 becomes 0xBB80.
- R7: Writes to 0x04 through 0x16 (even offsets), 0x1E, 0x20, 0x22, 0x6C and 0x6E are dropped, so these words keep reading 0x0000.
- R8: Each of the three volume words decodes as follows.
  - Bit 15 is the mute flag.
  - Left = 255*(bits[13:8] & M)/M and right = 255*(bits[5:0] & M)/M, truncated.
  - M is 0x3F for master, 0x1F for PCM-out and 0x0F for record gain.
- R9: A write to record select (0x1A) stores the value ANDed with 0x0707. The right source is bits [2:0] and the left source is bits [10:8].
- R10: A 16-bit read of an even in-window offset returns the stored word on rdData one clock after the access. A write is visible from the following clock.
- R11: An access of byte (size 0) or 32-bit (size 2) width, an odd address, or an address of 0x100 or above returns 0xFFFF on read and stores nothing on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSize | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| accAddr | input | 16 | Byte address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, registered |
| masterMute | output | 1 | Master mute flag |
| masterLeft | output | 8 | Master left level 0..255 |
| masterRight | output | 8 | Master right level 0..255 |
| pcmMute | output | 1 | PCM-out mute flag |
| pcmLeft | output | 8 | PCM-out left level |
| pcmRight | output | 8 | PCM-out right level |
| recMute | output | 1 | Record gain mute flag |
| recLeft | output | 8 | Record gain left level |
| recRight | output | 8 | Record gain right level |
| recSrcLeft | output | 3 | Left record source |
| recSrcRight | output | 3 | Right record source |
| frontDacRate | output | 16 | Front playback rate word |
| surrDacRate | output | 16 | Surround playback rate word |
| lfeDacRate | output | 16 | Low-frequency playback rate word |
| adcRate | output | 16 | Capture rate word |
| micRate | output | 16 | Microphone capture rate word |

## Verification
Read data is captured by the edge that ends the access and is checked half a clock later. Stores and forced rate words land on that same edge. The decoded volume, source and rate pins are combinational views of the stored words, so they are valid at the same sample point as read data. Every bench task drives on a falling edge and samples on the next falling edge, so each check falls one full register stage after its stimulus. The dropped and read-only cases are observed by reading the word back, or by watching the rate pins, after that single edge.

// File: rtl/mixer_pkg.sv
package mixer_pkg;

  localparam int WORD_W     = 16;
  localparam int SPAN_BYTES = 256;
  localparam int NUM_WORDS  = SPAN_BYTES / 2;
  localparam int IDX_W      = $clog2(NUM_WORDS);
  localparam int SRC_W      = 3;
  localparam int VRA_BIT    = 0;
  localparam int VRM_BIT    = 3;

  localparam logic [WORD_W-1:0] RATE_48K = 16'hBB80;
  localparam logic [WORD_W-1:0] SRC_KEEP = 16'h0707;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_RSVD = 2'd3} accSize_e;

  localparam logic [7:0] OFS_CODEC_RST  = 8'h00;
  localparam logic [7:0] OFS_MASTER_VOL = 8'h02;
  localparam logic [7:0] OFS_HEADPH     = 8'h04;
  localparam logic [7:0] OFS_AUX        = 8'h16;
  localparam logic [7:0] OFS_PCM_VOL    = 8'h18;
  localparam logic [7:0] OFS_REC_SRC    = 8'h1A;
  localparam logic [7:0] OFS_REC_GAIN   = 8'h1C;
  localparam logic [7:0] OFS_MIC_GAIN   = 8'h1E;
  localparam logic [7:0] OFS_GPIO       = 8'h20;
  localparam logic [7:0] OFS_SPATIAL    = 8'h22;
  localparam logic [7:0] OFS_PWR        = 8'h26;
  localparam logic [7:0] OFS_XID        = 8'h28;
  localparam logic [7:0] OFS_XCTL       = 8'h2A;
  localparam logic [7:0] OFS_RATE_FRONT = 8'h2C;
  localparam logic [7:0] OFS_RATE_SURR  = 8'h2E;
  localparam logic [7:0] OFS_RATE_LFE   = 8'h30;
  localparam logic [7:0] OFS_RATE_ADC   = 8'h32;
  localparam logic [7:0] OFS_RATE_MIC   = 8'h34;
  localparam logic [7:0] OFS_VND_A      = 8'h6C;
  localparam logic [7:0] OFS_VND_B      = 8'h6E;
  localparam logic [7:0] OFS_ID_HI      = 8'h7C;
  localparam logic [7:0] OFS_ID_LO      = 8'h7E;

  // Control-to-datapath strobes
  typedef struct packed {
    logic              wrEn;
    logic [IDX_W-1:0]  wrIdx;
    logic [WORD_W-1:0] wrVal;
    logic              forceAudioRates;
    logic              forceMicRate;
    logic              rdEn;
    logic              rdHit;
    logic [IDX_W-1:0]  rdIdx;
  } strobe_t;

  function automatic logic [IDX_W-1:0] idxOf(input logic [7:0] ofs);
    return ofs[IDX_W:1];
  endfunction

  function automatic logic [WORD_W-1:0] resetWord(input int unsigned idx);
    logic [7:0] ofs;
    ofs = 8'(idx * 2);
    case (ofs)
      OFS_PWR:        return 16'h000F;
      OFS_ID_HI:      return 16'h8384;
      OFS_ID_LO:      return 16'h7600;
      OFS_XID:        return 16'h0809;
      OFS_XCTL:       return 16'h0009;
      OFS_RATE_FRONT, OFS_RATE_SURR, OFS_RATE_LFE,
      OFS_RATE_ADC,   OFS_RATE_MIC:   return RATE_48K;
      OFS_MASTER_VOL: return 16'h8000;
      OFS_PCM_VOL,    OFS_REC_GAIN:   return 16'h8808;
      default:        return '0;
    endcase
  endfunction

  function automatic logic isFixedZero(input logic [7:0] ofs);
    return ((ofs >= OFS_HEADPH) && (ofs <= OFS_AUX)) ||
           (ofs == OFS_MIC_GAIN) || (ofs == OFS_GPIO) || (ofs == OFS_SPATIAL) ||
           (ofs == OFS_VND_A) || (ofs == OFS_VND_B);
  endfunction

  function automatic logic [7:0] scaleField(input logic [5:0] field, input logic [5:0] mask);
    int unsigned v;
    v = (255 * int'(field & mask)) / int'(mask);
    return v[7:0];
  endfunction

endpackage

// File: rtl/mixer_ctrl.sv
module mixer_ctrl
  import mixer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              vraOn,
  input  logic              vrmOn,
  input  logic [3:0]        pdNibble,
  output strobe_t           stb
);

  logic       inWindow;
  logic [7:0] ofs;

  always_comb begin
    inWindow = (accAddr < ADDR_W'(SPAN_BYTES)) && !accAddr[0] &&
               (accSize_e'(accSize) == SZ_HALF);
    ofs      = accAddr[7:0];

    stb                 = '0;
    stb.wrIdx           = idxOf(ofs);
    stb.rdIdx           = idxOf(ofs);
    stb.wrVal           = wrData;
    stb.rdEn            = accValid && !accWrite;
    stb.rdHit           = accValid && !accWrite && inWindow;

    if (accValid && accWrite && inWindow) begin
      case (ofs)
        OFS_PWR: begin
          stb.wrEn  = 1'b1;
          stb.wrVal = {wrData[WORD_W-1:4], pdNibble};
        end
        OFS_REC_SRC: begin
          stb.wrEn  = 1'b1;
          stb.wrVal = wrData & SRC_KEEP;
        end
        OFS_XCTL: begin
          stb.wrEn            = 1'b1;
          stb.forceAudioRates = !wrData[VRA_BIT];
          stb.forceMicRate    = !wrData[VRM_BIT];
        end
        OFS_RATE_FRONT, OFS_RATE_ADC: stb.wrEn = vraOn;
        OFS_RATE_MIC:                 stb.wrEn = vrmOn;
        OFS_ID_HI, OFS_ID_LO, OFS_XID: stb.wrEn = 1'b0;
        default:                      stb.wrEn = !isFixedZero(ofs);
      endcase
    end
  end

endmodule

// File: rtl/mixer_dp.sv
module mixer_dp
  import mixer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  output logic [WORD_W-1:0] rdData,
  output logic              vraOn,
  output logic              vrmOn,
  output logic [3:0]        pdNibble,
  output logic [2:0]        volMute,
  output logic [7:0]        volLeft  [3],
  output logic [7:0]        volRight [3],
  output logic [SRC_W-1:0]  recSrcLeft,
  output logic [SRC_W-1:0]  recSrcRight,
  output logic [WORD_W-1:0] frontDacRate,
  output logic [WORD_W-1:0] surrDacRate,
  output logic [WORD_W-1:0] lfeDacRate,
  output logic [WORD_W-1:0] adcRate,
  output logic [WORD_W-1:0] micRate
);

  localparam logic [IDX_W-1:0] I_FRONT = idxOf(OFS_RATE_FRONT);
  localparam logic [IDX_W-1:0] I_SURR  = idxOf(OFS_RATE_SURR);
  localparam logic [IDX_W-1:0] I_LFE   = idxOf(OFS_RATE_LFE);
  localparam logic [IDX_W-1:0] I_ADC   = idxOf(OFS_RATE_ADC);
  localparam logic [IDX_W-1:0] I_MIC   = idxOf(OFS_RATE_MIC);
  localparam logic [IDX_W-1:0] I_XCTL  = idxOf(OFS_XCTL);
  localparam logic [IDX_W-1:0] I_PWR   = idxOf(OFS_PWR);
  localparam logic [IDX_W-1:0] I_SRC   = idxOf(OFS_REC_SRC);

  localparam logic [IDX_W-1:0] VOL_IDX  [3] = '{idxOf(OFS_MASTER_VOL), idxOf(OFS_PCM_VOL), idxOf(OFS_REC_GAIN)};
  localparam logic [5:0]       VOL_MASK [3] = '{6'h3F, 6'h1F, 6'h0F};

  logic [WORD_W-1:0] regs [NUM_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) regs[i] <= resetWord(i);
      rdData <= '0;
    end else begin
      if (stb.wrEn) regs[stb.wrIdx] <= stb.wrVal;
      if (stb.forceAudioRates) begin
        regs[I_FRONT] <= RATE_48K;
        regs[I_ADC]   <= RATE_48K;
      end
      if (stb.forceMicRate) regs[I_MIC] <= RATE_48K;
      if (stb.rdEn) rdData <= stb.rdHit ? regs[stb.rdIdx] : '1;
    end
  end

  assign vraOn    = regs[I_XCTL][VRA_BIT];
  assign vrmOn    = regs[I_XCTL][VRM_BIT];
  assign pdNibble = regs[I_PWR][3:0];

  for (genvar c = 0; c < 3; c++) begin : g_vol
    logic [WORD_W-1:0] word;
    assign word        = regs[VOL_IDX[c]];
    assign volMute[c]  = word[15];
    assign volLeft[c]  = scaleField(word[13:8], VOL_MASK[c]);
    assign volRight[c] = scaleField(word[5:0], VOL_MASK[c]);
  end

  assign recSrcRight  = regs[I_SRC][SRC_W-1:0];
  assign recSrcLeft   = regs[I_SRC][8 +: SRC_W];
  assign frontDacRate = regs[I_FRONT];
  assign surrDacRate  = regs[I_SURR];
  assign lfeDacRate   = regs[I_LFE];
  assign adcRate      = regs[I_ADC];
  assign micRate      = regs[I_MIC];

endmodule

// File: rtl/mixer_regfile.sv
module mixer_regfile
  import mixer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic [1:0]        accSize,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              masterMute,
  output logic [7:0]        masterLeft,
  output logic [7:0]        masterRight,
  output logic              pcmMute,
  output logic [7:0]        pcmLeft,
  output logic [7:0]        pcmRight,
  output logic              recMute,
  output logic [7:0]        recLeft,
  output logic [7:0]        recRight,
  output logic [2:0]        recSrcLeft,
  output logic [2:0]        recSrcRight,
  output logic [15:0]       frontDacRate,
  output logic [15:0]       surrDacRate,
  output logic [15:0]       lfeDacRate,
  output logic [15:0]       adcRate,
  output logic [15:0]       micRate
);

  strobe_t    stb;
  logic       vraOn;
  logic       vrmOn;
  logic [3:0] pdNibble;
  logic [2:0] volMute;
  logic [7:0] volLeft  [3];
  logic [7:0] volRight [3];

  mixer_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accSize  (accSize),
    .accAddr  (accAddr),
    .wrData   (wrData),
    .vraOn    (vraOn),
    .vrmOn    (vrmOn),
    .pdNibble (pdNibble),
    .stb      (stb)
  );

  mixer_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rdData       (rdData),
    .vraOn        (vraOn),
    .vrmOn        (vrmOn),
    .pdNibble     (pdNibble),
    .volMute      (volMute),
    .volLeft      (volLeft),
    .volRight     (volRight),
    .recSrcLeft   (recSrcLeft),
    .recSrcRight  (recSrcRight),
    .frontDacRate (frontDacRate),
    .surrDacRate  (surrDacRate),
    .lfeDacRate   (lfeDacRate),
    .adcRate      (adcRate),
    .micRate      (micRate)
  );

  assign masterMute  = volMute[0];
  assign masterLeft  = volLeft[0];
  assign masterRight = volRight[0];
  assign pcmMute     = volMute[1];
  assign pcmLeft     = volLeft[1];
  assign pcmRight    = volRight[1];
  assign recMute     = volMute[2];
  assign recLeft     = volLeft[2];
  assign recRight    = volRight[2];

endmodule

// File: rtl/mixer_regfile_chk.sv
module mixer_regfile_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic              accWrite,
  input logic [1:0]        accSize,
  input logic [ADDR_W-1:0] accAddr,
  input logic [15:0]       wrData,
  input logic [15:0]       rdData,
  input logic [15:0]       frontDacRate,
  input logic [15:0]       adcRate,
  input logic [15:0]       micRate,
  input logic              vraOn,
  input logic [3:0]        pdNibble
);

  logic halfWr;
  assign halfWr = accValid && accWrite && (accSize == 2'd1);

  // R11
  bad_access_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && ((accSize != 2'd1) || accAddr[0] || (accAddr >= ADDR_W'(256))))
      |=> (rdData == 16'hFFFF));

  // R4
  id_word_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && (accSize == 2'd1) && (accAddr == ADDR_W'(16'h007C)))
      |=> (rdData == 16'h8384));

  // R3
  pwr_nibble_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && (accAddr == ADDR_W'(16'h0026))) |=> (pdNibble == $past(pdNibble)));

  // R5
  front_rate_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && (accAddr == ADDR_W'(16'h002C)) && !vraOn) |=> $stable(frontDacRate));

  // R6
  audio_rate_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && (accAddr == ADDR_W'(16'h002A)) && !wrData[0])
      |=> ((frontDacRate == 16'hBB80) && (adcRate == 16'hBB80)));

  // R6
  mic_rate_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halfWr && (accAddr == ADDR_W'(16'h002A)) && !wrData[3]) |=> (micRate == 16'hBB80));

endmodule

bind mixer_regfile mixer_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accSize      (accSize),
  .accAddr      (accAddr),
  .wrData       (wrData),
  .rdData       (rdData),
  .frontDacRate (frontDacRate),
  .adcRate      (adcRate),
  .micRate      (micRate),
  .vraOn        (vraOn),
  .pdNibble     (pdNibble)
);

// File: tb/tb_mixer_regfile.sv
`timescale 1ns/1ps
module tb_mixer_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [1:0]  accSize = 2'd1;
  logic [15:0] accAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        masterMute, pcmMute, recMute;
  logic [7:0]  masterLeft, masterRight, pcmLeft, pcmRight, recLeft, recRight;
  logic [2:0]  recSrcLeft, recSrcRight;
  logic [15:0] frontDacRate, surrDacRate, lfeDacRate, adcRate, micRate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mixer_regfile dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSize(accSize), .accAddr(accAddr), .wrData(wrData), .rdData(rdData),
    .masterMute(masterMute), .masterLeft(masterLeft), .masterRight(masterRight),
    .pcmMute(pcmMute), .pcmLeft(pcmLeft), .pcmRight(pcmRight),
    .recMute(recMute), .recLeft(recLeft), .recRight(recRight),
    .recSrcLeft(recSrcLeft), .recSrcRight(recSrcRight),
    .frontDacRate(frontDacRate), .surrDacRate(surrDacRate), .lfeDacRate(lfeDacRate),
    .adcRate(adcRate), .micRate(micRate)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [15:0] data;
    logic [15:0] expRd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 16'h0026, 16'h0000, 16'h000F, 4'd1},  // R1
    '{1'b0, 2'd1, 16'h007C, 16'h0000, 16'h8384, 4'd1},  // R1
    '{1'b0, 2'd1, 16'h007E, 16'h0000, 16'h7600, 4'd1},  // R1
    '{1'b0, 2'd1, 16'h0028, 16'h0000, 16'h0809, 4'd1},  // R1
    '{1'b0, 2'd1, 16'h002A, 16'h0000, 16'h0009, 4'd1},  // R1
    '{1'b0, 2'd1, 16'h002E, 16'h0000, 16'hBB80, 4'd2},  // R2
    '{1'b0, 2'd1, 16'h0030, 16'h0000, 16'hBB80, 4'd2},  // R2
    '{1'b0, 2'd1, 16'h0002, 16'h0000, 16'h8000, 4'd2},  // R2
    '{1'b0, 2'd1, 16'h0018, 16'h0000, 16'h8808, 4'd2},  // R2
    '{1'b0, 2'd1, 16'h001C, 16'h0000, 16'h8808, 4'd2},  // R2
    '{1'b1, 2'd1, 16'h0026, 16'h1230, 16'h0000, 4'd3},
    '{1'b0, 2'd1, 16'h0026, 16'h0000, 16'h123F, 4'd3},  // R3
    '{1'b1, 2'd1, 16'h007C, 16'h0000, 16'h0000, 4'd4},
    '{1'b0, 2'd1, 16'h007C, 16'h0000, 16'h8384, 4'd4},  // R4
    '{1'b1, 2'd1, 16'h0028, 16'hFFFF, 16'h0000, 4'd4},
    '{1'b0, 2'd1, 16'h0028, 16'h0000, 16'h0809, 4'd4},  // R4
    '{1'b1, 2'd1, 16'h0004, 16'h1234, 16'h0000, 4'd7},
    '{1'b0, 2'd1, 16'h0004, 16'h0000, 16'h0000, 4'd7},  // R7
    '{1'b1, 2'd1, 16'h006E, 16'h5555, 16'h0000, 4'd7},
    '{1'b0, 2'd1, 16'h006E, 16'h0000, 16'h0000, 4'd7},  // R7
    '{1'b1, 2'd1, 16'h0022, 16'hAAAA, 16'h0000, 4'd7},
    '{1'b0, 2'd1, 16'h0022, 16'h0000, 16'h0000, 4'd7},  // R7
    '{1'b1, 2'd1, 16'h001A, 16'hFFFF, 16'h0000, 4'd9},
    '{1'b0, 2'd1, 16'h001A, 16'h0000, 16'h0707, 4'd9},  // R9
    '{1'b1, 2'd1, 16'h005A, 16'hBEEF, 16'h0000, 4'd10},
    '{1'b0, 2'd1, 16'h005A, 16'h0000, 16'hBEEF, 4'd10}, // R10
    '{1'b1, 2'd1, 16'h002C, 16'hAC44, 16'h0000, 4'd5},
    '{1'b0, 2'd1, 16'h002C, 16'h0000, 16'hAC44, 4'd5},  // R5
    '{1'b1, 2'd1, 16'h0034, 16'h5622, 16'h0000, 4'd5},
    '{1'b0, 2'd1, 16'h0034, 16'h0000, 16'h5622, 4'd5},  // R5
    '{1'b1, 2'd1, 16'h002A, 16'h0000, 16'h0000, 4'd6},
    '{1'b0, 2'd1, 16'h002C, 16'h0000, 16'hBB80, 4'd6},  // R6
    '{1'b0, 2'd1, 16'h0034, 16'h0000, 16'hBB80, 4'd6},  // R6
    '{1'b0, 2'd1, 16'h002A, 16'h0000, 16'h0000, 4'd6},  // R6
    '{1'b1, 2'd1, 16'h002C, 16'h1F40, 16'h0000, 4'd5},
    '{1'b0, 2'd1, 16'h002C, 16'h0000, 16'hBB80, 4'd5},  // R5
    '{1'b1, 2'd1, 16'h002A, 16'h0001, 16'h0000, 4'd5},
    '{1'b1, 2'd1, 16'h0034, 16'h3E80, 16'h0000, 4'd5},
    '{1'b0, 2'd1, 16'h0034, 16'h0000, 16'hBB80, 4'd5},  // R5
    '{1'b1, 2'd1, 16'h0032, 16'h3E80, 16'h0000, 4'd5},
    '{1'b0, 2'd1, 16'h0032, 16'h0000, 16'h3E80, 4'd5},  // R5
    '{1'b1, 2'd0, 16'h005A, 16'h0000, 16'h0000, 4'd11},
    '{1'b0, 2'd1, 16'h005A, 16'h0000, 16'hBEEF, 4'd11}, // R11
    '{1'b0, 2'd0, 16'h005A, 16'h0000, 16'hFFFF, 4'd11}, // R11
    '{1'b0, 2'd2, 16'h005A, 16'h0000, 16'hFFFF, 4'd11}, // R11
    '{1'b1, 2'd1, 16'h0100, 16'h1111, 16'h0000, 4'd11},
    '{1'b0, 2'd1, 16'h0100, 16'h0000, 16'hFFFF, 4'd11}, // R11
    '{1'b0, 2'd1, 16'h0000, 16'h0000, 16'h0000, 4'd11}, // R11
    '{1'b1, 2'd1, 16'h005B, 16'h0000, 16'h0000, 4'd11},
    '{1'b0, 2'd1, 16'h005A, 16'h0000, 16'hBEEF, 4'd11}, // R11
    '{1'b0, 2'd1, 16'h005B, 16'h0000, 16'hFFFF, 4'd11}  // R11
  };

  // One access: drive on a falling edge, sample on the next falling edge
  task automatic access(input logic wr, input logic [1:0] sz,
                        input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    accValid = 1'b1;
    accWrite = wr;
    accSize  = sz;
    accAddr  = addr;
    wrData   = data;
    @(negedge clk);
    accValid = 1'b0;
    accWrite = 1'b0;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();

    // R2: decoded outputs after reset
    check("R2 masterMute", 16'(masterMute), 16'd1);
    check("R2 masterLeft", 16'(masterLeft), 16'd0);
    check("R2 pcmLeft", 16'(pcmLeft), 16'd65);
    check("R2 pcmRight", 16'(pcmRight), 16'd65);
    check("R2 recLeft", 16'(recLeft), 16'd136);
    check("R2 recMute", 16'(recMute), 16'd1);
    check("R2 frontDacRate", frontDacRate, 16'hBB80);
    check("R2 lfeDacRate", lfeDacRate, 16'hBB80);
    check("R2 micRate", micRate, 16'hBB80);
    check("R1 recSrc", {10'd0, recSrcLeft, recSrcRight}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].data);
      if (!VECS[i].wr)
        check($sformatf("R%0d vec%0d", VECS[i].req, i), rdData, VECS[i].expRd);
    end

    // R5 / R6: rate pins after the table walk
    check("R5 adcRate", adcRate, 16'h3E80);
    check("R6 frontDacRate", frontDacRate, 16'hBB80);
    check("R6 micRate", micRate, 16'hBB80);
    access(1'b1, 2'd1, 16'h002E, 16'h1234);
    check("R5 surrDacRate", surrDacRate, 16'h1234);

    // R8: volume decode
    access(1'b1, 2'd1, 16'h0002, 16'h1F3F);
    check("R8 masterMute", 16'(masterMute), 16'd0);
    check("R8 masterLeft", 16'(masterLeft), 16'd125);
    check("R8 masterRight", 16'(masterRight), 16'd255);
    access(1'b1, 2'd1, 16'h001C, 16'h0F05);
    check("R8 recLeft", 16'(recLeft), 16'd255);
    check("R8 recRight", 16'(recRight), 16'd85);
    check("R8 recMute", 16'(recMute), 16'd0);
    access(1'b1, 2'd1, 16'h0018, 16'h9F00);
    check("R8 pcmMute", 16'(pcmMute), 16'd1);
    check("R8 pcmLeft", 16'(pcmLeft), 16'd255);
    check("R8 pcmRight", 16'(pcmRight), 16'd0);

    // R9: source fields
    access(1'b1, 2'd1, 16'h001A, 16'h0402);
    check("R9 recSrcLeft", 16'(recSrcLeft), 16'd4);
    check("R9 recSrcRight", 16'(recSrcRight), 16'd2);

    // R1: reset clears ordinary words again
    doReset();
    access(1'b0, 2'd1, 16'h005A, 16'h0000);
    check("R1 cleared word", rdData, 16'h0000);
    access(1'b0, 2'd1, 16'h002C, 16'h0000);
    check("R2 front rate after reset", rdData, 16'hBB80);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule